// File: doc/BRIEF.md
# Half-Warp Memory Transaction Coalescer

This block turns one load or store from a group of sixteen lanes into the smallest list of aligned memory transactions that serves every active lane. For each request it takes one address per lane, a mask of active lanes, an access size and a rule-set select. It then issues one transaction per cycle on a valid/ready handshake. Each transaction carries a segment base address, a segment size in bytes and the mask of lanes it serves.

There are two rule sets. The strict rule set merges only an ordered pattern, where lane k touches word k of one aligned region. Any other pattern falls back to one transaction per active lane. The relaxed rule set accepts any pattern and issues one transaction for each distinct aligned segment that is touched.

The block takes one request at a time. A new request is accepted only after every transaction of the previous request has been consumed. A one-cycle completion pulse marks the end of each request.

Top module: `hw_coalescer`

## Requirements
- R1: `req_ready` is high only while no request is being served. A request is taken when `req_valid` and `req_ready` are both high. While a request is in service, `req_ready` is low and `req_valid` is ignored.
- R2: `acc_size` is the base-2 log of the bytes per lane: 0=1 B, 1=2 B, 2=4 B, 3=8 B, 4=16 B. In relaxed mode (`relaxed_mode`=1) the segment is 32 B for 1 B accesses, 64 B for 2 B accesses, and 128 B for 4 B or 8 B accesses. `txn_bytes` gives the segment size in bytes.
- R3: In relaxed mode, exactly one transaction is issued for each distinct segment touched by an active lane, whatever the lane order and even when addresses repeat. Its `txn_lanes` holds exactly the active lanes inside that segment (bit k = lane k).
- R4: In strict mode with 4 B or 8 B accesses, a request is coalesced when the following holds. Every active lane k addresses byte offset k*size inside one region of 16*size bytes aligned to its size. A coalesced request then gives a single transaction: 64 B for 4 B accesses, 128 B for 8 B accesses.
- R5: In strict mode with 16 B accesses, the same ordered pattern over a 256 B aligned region gives two 128 B transactions. One is at the region base and serves lanes 0-7. The other is at base+128 and serves lanes 8-15. A half with no active lane gives no transaction.
- R6: In strict mode, a request that breaks the ordered pattern gives one transaction per active lane. Each has the access size, sits at that lane's address, and serves that lane alone, even when lanes share an address.
- R7: Inactive lanes have no effect. Their addresses neither break a strict pattern nor add a segment.
- R8: The transactions of a request come out in ascending address order. Equal addresses in the per-lane fallback come out in ascending lane order.
- R9: A request with no active lane issues no transaction.
- R10: `done` is high for exactly one cycle, in the cycle after the last transaction handshake. For a request with no active lane, it is high in the cycle after acceptance. `req_ready` rises in the cycle after `done`.
- R11: While `txn_valid` is high and `txn_ready` is low, the transaction fields and `txn_valid` stay unchanged.
- R12: After reset, `req_ready` is 1, `txn_valid` is 0 and `done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | LANES*ADDR_W | Byte address per lane, lane k at bits k*ADDR_W upward |
| req_active | input | LANES | Active lane mask |
| acc_size | input | 3 | Log2 of bytes per lane |
| relaxed_mode | input | 1 | 1 = relaxed segment rules, 0 = strict ordered rules |
| txn_valid | output | 1 | Transaction present |
| txn_ready | input | 1 | Consumer takes the transaction |
| txn_addr | output | ADDR_W | Segment base address |
| txn_bytes | output | MAX_SEG_LOG2+1 | Segment size in bytes |
| txn_lanes | output | LANES | Lanes served by this transaction |
| done | output | 1 | One-cycle end-of-request pulse |

## Verification
The assertions assume a few things about the inputs. Each lane address is aligned to its access size. `acc_size` is 2 to 4 in strict mode and 0 to 3 in relaxed mode. `txn_ready` may change in any cycle. The stimulus builds every address as a multiple of the access size and picks the size only from the legal set for the chosen mode. It drives `txn_ready` from a random stream and holds `req_valid` high with junk fields while a request is in service. Inactive lanes are given arbitrary addresses, so that any effect they have would show up in the transaction list.

// File: rtl/hwc_pkg.sv
// hwc_pkg: shared size codes and segment-size helpers for the coalescer.
// Assumes sizes are coded as log2 of bytes per lane.
package hwc_pkg;

    typedef enum logic [2:0] {
        ACC_1B  = 3'd0,
        ACC_2B  = 3'd1,
        ACC_4B  = 3'd2,
        ACC_8B  = 3'd3,
        ACC_16B = 3'd4
    } acc_size_e;

    // Smaller of two shift amounts, used to cap the segment size.
    function automatic logic [3:0] cap_shift(input int unsigned want, input int unsigned cap);
        if (want > cap) return 4'(cap);
        return 4'(want);
    endfunction

endpackage

// File: rtl/hwc_rule_eval.sv
// hwc_rule_eval: decides, for an incoming request, the segment shift
// (log2 of the transaction size) and whether the per-lane fallback applies.
// Assumes lane addresses are aligned to the access size.
module hwc_rule_eval #(
    parameter int LANES          = 16,
    parameter int ADDR_W         = 32,
    parameter int MAX_SEG_LOG2   = 7,
    parameter int RELAX_MIN_LOG2 = 5
) (
    input  logic [LANES*ADDR_W-1:0] addr_flat,
    input  logic [LANES-1:0]        active,
    input  logic [2:0]              size_log2,
    input  logic                    relaxed,
    output logic [3:0]              seg_shift,
    output logic                    per_lane
);
    localparam int LANE_W = $clog2(LANES);

    logic [ADDR_W-1:0] region_mask;
    logic [ADDR_W-1:0] ref_addr;
    logic [LANES-1:0]  lane_ok;
    logic              pattern_ok;

    // Low-bit mask of the ordered region (LANES words of the access size).
    always_comb begin
        region_mask = (ADDR_W'(1) << (int'(size_log2) + LANE_W)) - ADDR_W'(1);
    end

    // Reference address: the lowest-numbered active lane.
    always_comb begin
        ref_addr = '0;
        for (int k = LANES - 1; k >= 0; k--) begin
            if (active[k]) ref_addr = addr_flat[k*ADDR_W +: ADDR_W];
        end
    end

    // Per-lane ordered-pattern test; inactive lanes always pass.
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [ADDR_W-1:0] a;
        logic [ADDR_W-1:0] want_off;
        assign a        = addr_flat[k*ADDR_W +: ADDR_W];
        assign want_off = ADDR_W'(k) << size_log2;
        assign lane_ok[k] = !active[k] ||
                            (((a & region_mask) == want_off) &&
                             ((a & ~region_mask) == (ref_addr & ~region_mask)));
    end

    assign pattern_ok = &lane_ok;

    // Pick the segment shift from rule set and pattern outcome.
    always_comb begin
        if (relaxed) begin
            seg_shift = hwc_pkg::cap_shift(int'(size_log2) + RELAX_MIN_LOG2, MAX_SEG_LOG2);
            per_lane  = 1'b0;
        end else if (pattern_ok) begin
            seg_shift = hwc_pkg::cap_shift(int'(size_log2) + LANE_W, MAX_SEG_LOG2);
            per_lane  = 1'b0;
        end else begin
            seg_shift = {1'b0, size_log2};
            per_lane  = 1'b1;
        end
    end

endmodule

// File: rtl/hwc_seg_pick.sv
// hwc_seg_pick: among pending lanes, finds the lowest segment base and the
// lanes it serves; in per-lane mode it serves only the lowest such lane.
// Assumes seg_shift is below ADDR_W.
module hwc_seg_pick #(
    parameter int LANES  = 16,
    parameter int ADDR_W = 32
) (
    input  logic [LANES*ADDR_W-1:0] addr_flat,
    input  logic [LANES-1:0]        pending,
    input  logic [3:0]              seg_shift,
    input  logic                    per_lane,
    output logic [ADDR_W-1:0]       min_base,
    output logic [LANES-1:0]        lanes
);
    localparam int LANE_W = $clog2(LANES);

    logic [ADDR_W-1:0] seg_base [LANES];
    logic [ADDR_W-1:0] low_mask;
    logic [LANE_W-1:0] min_idx;
    logic [LANES-1:0]  match;

    assign low_mask = (ADDR_W'(1) << seg_shift) - ADDR_W'(1);

    // Segment base of every lane.
    for (genvar k = 0; k < LANES; k++) begin : g_base
        assign seg_base[k] = addr_flat[k*ADDR_W +: ADDR_W] & ~low_mask;
    end

    // Lowest base over pending lanes; strict compare keeps the lowest index on ties.
    always_comb begin
        logic found;
        found    = 1'b0;
        min_base = '0;
        min_idx  = '0;
        for (int k = 0; k < LANES; k++) begin
            if (pending[k] && (!found || seg_base[k] < min_base)) begin
                found    = 1'b1;
                min_base = seg_base[k];
                min_idx  = LANE_W'(k);
            end
        end
    end

    // Pending lanes that fall in the chosen segment.
    for (genvar k = 0; k < LANES; k++) begin : g_match
        assign match[k] = pending[k] && (seg_base[k] == min_base);
    end

    // Served lanes: whole segment, or the single lowest lane in fallback.
    always_comb begin
        if (per_lane) lanes = LANES'(1) << min_idx;
        else          lanes = match;
    end

endmodule

// File: rtl/hw_coalescer.sv
// hw_coalescer: top of the half-warp coalescer. Captures one request, then
// issues its aligned transactions in ascending address order, one per
// handshake, and pulses done when all are consumed.
// Assumes the input rules listed in the brief (aligned addresses, legal sizes).
module hw_coalescer #(
    parameter int LANES          = 16,
    parameter int ADDR_W         = 32,
    parameter int MAX_SEG_LOG2   = 7,
    parameter int RELAX_MIN_LOG2 = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic [LANES*ADDR_W-1:0]   req_addr,
    input  logic [LANES-1:0]          req_active,
    input  logic [2:0]                acc_size,
    input  logic                      relaxed_mode,
    output logic                      txn_valid,
    input  logic                      txn_ready,
    output logic [ADDR_W-1:0]         txn_addr,
    output logic [MAX_SEG_LOG2:0]     txn_bytes,
    output logic [LANES-1:0]          txn_lanes,
    output logic                      done
);
    localparam int BYTES_W = MAX_SEG_LOG2 + 1;

    logic                    busy_q;
    logic [LANES-1:0]        pend_q;
    logic [LANES*ADDR_W-1:0] addr_q;
    logic [3:0]              shift_q;
    logic                    per_lane_q;
    logic [3:0]              shift_d;
    logic                    per_lane_d;
    logic                    accept;
    logic                    fire;

    hwc_rule_eval #(
        .LANES(LANES), .ADDR_W(ADDR_W),
        .MAX_SEG_LOG2(MAX_SEG_LOG2), .RELAX_MIN_LOG2(RELAX_MIN_LOG2)
    ) rule_i (
        .addr_flat (req_addr),
        .active    (req_active),
        .size_log2 (acc_size),
        .relaxed   (relaxed_mode),
        .seg_shift (shift_d),
        .per_lane  (per_lane_d)
    );

    hwc_seg_pick #(.LANES(LANES), .ADDR_W(ADDR_W)) pick_i (
        .addr_flat (addr_q),
        .pending   (pend_q),
        .seg_shift (shift_q),
        .per_lane  (per_lane_q),
        .min_base  (txn_addr),
        .lanes     (txn_lanes)
    );

    assign req_ready = !busy_q;
    assign accept    = req_valid && req_ready;
    assign txn_valid = busy_q && (pend_q != '0);
    assign fire      = txn_valid && txn_ready;
    assign done      = busy_q && (pend_q == '0);
    assign txn_bytes = BYTES_W'(1) << shift_q;

    // Request capture and service state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q     <= 1'b0;
            pend_q     <= '0;
            addr_q     <= '0;
            shift_q    <= '0;
            per_lane_q <= 1'b0;
        end else if (accept) begin
            busy_q     <= 1'b1;
            pend_q     <= req_active;
            addr_q     <= req_addr;
            shift_q    <= shift_d;
            per_lane_q <= per_lane_d;
        end else if (fire) begin
            pend_q <= pend_q & ~txn_lanes;
        end else if (done) begin
            busy_q <= 1'b0;
        end
    end

    // Last issued address within the current request, kept for the order check.
    logic              seen_q;
    logic [ADDR_W-1:0] last_addr_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q      <= 1'b0;
            last_addr_q <= '0;
        end else if (accept) begin
            seen_q <= 1'b0;
        end else if (fire) begin
            seen_q      <= 1'b1;
            last_addr_q <= txn_addr;
        end
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!txn_valid && !done));

    p_size_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> ($onehot(txn_bytes) && ((txn_addr & ADDR_W'(txn_bytes - 1'b1)) == '0)));

    p_lanes_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> ((txn_lanes != '0) && ((txn_lanes & ~pend_q) == '0)));

    p_ascending_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && seen_q) |-> (txn_addr >= last_addr_q));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready));

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && !txn_ready) |=>
            (txn_valid && $stable(txn_addr) && $stable(txn_bytes) && $stable(txn_lanes)));

endmodule

// File: tb/hw_coalescer_tb_top.sv
// Bench: behavioural reference model (sorted queues) compared every clock.
module hw_coalescer_tb_top;
    localparam int LANES  = 16;
    localparam int ADDR_W = 32;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    req_valid = 1'b0;
    logic                    req_ready;
    logic [LANES*ADDR_W-1:0] req_addr = '0;
    logic [LANES-1:0]        req_active = '0;
    logic [2:0]              acc_size = 3'd2;
    logic                    relaxed_mode = 1'b0;
    logic                    txn_valid;
    logic                    txn_ready = 1'b0;
    logic [ADDR_W-1:0]       txn_addr;
    logic [7:0]              txn_bytes;
    logic [LANES-1:0]        txn_lanes;
    logic                    done;

    always #2.5 clk = ~clk;

    hw_coalescer dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_active(req_active), .acc_size(acc_size),
        .relaxed_mode(relaxed_mode), .txn_valid(txn_valid), .txn_ready(txn_ready),
        .txn_addr(txn_addr), .txn_bytes(txn_bytes), .txn_lanes(txn_lanes), .done(done)
    );

    typedef struct {
        int unsigned addr;
        int unsigned bytes;
        int unsigned lanes;
    } txn_t;

    txn_t        exp_q[$];
    int unsigned la[LANES];
    int          n_checks = 0;
    int          n_fail   = 0;
    int          ready_pct = 60;

    task automatic check(input logic ok, input string tag, input longint act, input longint expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
        end
    endtask

    // Reference: build the expected transaction list from the stated rules.
    task automatic build_model(input bit relax, input int sz, input int unsigned mask);
        int unsigned bytes_per;
        int unsigned seg;
        bit          ordered;
        int          refl;
        int unsigned region;
        exp_q.delete();
        bytes_per = 1 << sz;
        ordered   = 1'b1;
        refl      = -1;
        region    = 16 * bytes_per;
        for (int k = 0; k < LANES; k++) if (mask[k] && refl < 0) refl = k;
        if (!relax) begin
            for (int k = 0; k < LANES; k++) begin
                if (mask[k]) begin
                    if ((la[k] % region) != k * bytes_per) ordered = 1'b0;
                    if ((la[k] / region) != (la[refl] / region)) ordered = 1'b0;
                end
            end
        end
        if (relax || ordered) begin
            int unsigned bases[$];
            if (relax) seg = (32 << sz) > 128 ? 128 : (32 << sz);
            else       seg = region > 128 ? 128 : region;
            for (int k = 0; k < LANES; k++) begin
                if (mask[k]) begin
                    int unsigned b;
                    int hits[$];
                    b = la[k] / seg * seg;
                    hits = bases.find_index(x) with (x == b);
                    if (hits.size() == 0) bases.push_back(b);
                end
            end
            bases.sort();
            foreach (bases[i]) begin
                txn_t t;
                t.addr = bases[i]; t.bytes = seg; t.lanes = 0;
                for (int k = 0; k < LANES; k++)
                    if (mask[k] && (la[k] / seg * seg) == bases[i]) t.lanes |= (1 << k);
                exp_q.push_back(t);
            end
        end else begin
            longint unsigned keys[$];
            for (int k = 0; k < LANES; k++)
                if (mask[k]) keys.push_back((longint'(la[k] / bytes_per * bytes_per) << 8) | k);
            keys.sort();
            foreach (keys[i]) begin
                txn_t t;
                t.addr  = int'(keys[i] >> 8);
                t.bytes = bytes_per;
                t.lanes = 1 << int'(keys[i] & 8'hff);
                exp_q.push_back(t);
            end
        end
    endtask

    // Send one request and follow it cycle by cycle against the model.
    task automatic run_req(input bit relax, input int sz, input int unsigned mask, input string tag);
        int n_txn;
        build_model(relax, sz, mask);
        n_txn = exp_q.size();
        check(req_ready == 1'b1, {tag, " R1 ready before request"}, req_ready, 1);
        req_valid    = 1'b1;
        relaxed_mode = relax;
        acc_size     = 3'(sz);
        req_active   = 16'(mask);
        for (int k = 0; k < LANES; k++) req_addr[k*ADDR_W +: ADDR_W] = la[k];
        @(posedge clk); @(negedge clk);
        // Junk request held during service must be ignored (R1).
        req_active = 16'hffff;
        relaxed_mode = ~relax;
        for (int k = 0; k < LANES; k++) req_addr[k*ADDR_W +: ADDR_W] = $urandom;
        while (exp_q.size() > 0) begin
            check(req_ready == 1'b0, {tag, " R1 ready low in service"}, req_ready, 0);
            check(txn_valid == 1'b1, {tag, " R11 valid"}, txn_valid, 1);
            check(txn_addr == exp_q[0].addr, {tag, " R8 addr"}, txn_addr, exp_q[0].addr);
            check(txn_bytes == 8'(exp_q[0].bytes), {tag, " R2 bytes"}, txn_bytes, exp_q[0].bytes);
            check(txn_lanes == 16'(exp_q[0].lanes), {tag, " R3 lanes"}, txn_lanes, exp_q[0].lanes);
            check(done == 1'b0, {tag, " R10 no early done"}, done, 0);
            txn_ready = ($urandom % 100) < ready_pct;
            if (txn_ready) void'(exp_q.pop_front());
            @(posedge clk); @(negedge clk);
        end
        txn_ready = 1'b0;
        check(done == 1'b1, {tag, " R10 done pulse"}, done, 1);
        check(txn_valid == 1'b0, {tag, " R9 no extra txn"}, txn_valid, 0);
        req_valid = 1'b0;
        @(posedge clk); @(negedge clk);
        check(done == 1'b0, {tag, " R10 single-cycle done"}, done, 0);
        check(req_ready == 1'b1, {tag, " R1 ready after done"}, req_ready, 1);
        if (n_txn < 0) $display("unreachable");
    endtask

    task automatic fill_ordered(input int unsigned base, input int sz);
        for (int k = 0; k < LANES; k++) la[k] = base + k * (1 << sz);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R12 reset state
        check(req_ready == 1'b1, "R12 ready", req_ready, 1);
        check(txn_valid == 1'b0, "R12 txn_valid", txn_valid, 0);
        check(done == 1'b0, "R12 done", done, 0);
        rst_n = 1'b1;
        @(negedge clk);

        fill_ordered(32'h1000, 2); run_req(0, 2, 16'hffff, "R4 strict 4B");
        fill_ordered(32'h1400, 2);
        for (int k = 0; k < LANES; k++) if (k % 8 >= 4) la[k] = $urandom;
        run_req(0, 2, 16'h0f0f, "R7 strict divergent");
        fill_ordered(32'h2000, 3); run_req(0, 3, 16'hffff, "R4 strict 8B");
        fill_ordered(32'h3000, 4); run_req(0, 4, 16'hffff, "R5 strict 16B");
        fill_ordered(32'h3100, 4); run_req(0, 4, 16'h00ff, "R5 strict 16B low half");
        fill_ordered(32'h1000, 2); la[0] = 32'h1004; la[1] = 32'h1000;
        run_req(0, 2, 16'hffff, "R6 permuted");
        fill_ordered(32'h1010, 2); run_req(0, 2, 16'hffff, "R6 misaligned");
        for (int k = 0; k < LANES; k++) la[k] = 32'h5000;
        run_req(0, 3, 16'hffff, "R6 R8 duplicates");
        for (int k = 0; k < LANES; k++) la[k] = 32'h6000 + (15 - k) * 16;
        run_req(1, 2, 16'hffff, "R3 relaxed reversed");
        for (int k = 0; k < LANES; k++) la[k] = 32'h7003;
        run_req(1, 0, 16'hffff, "R2 relaxed 1B same");
        for (int k = 0; k < LANES; k++) la[k] = $urandom;
        run_req(0, 2, 16'h0000, "R9 empty");

        for (int i = 0; i < 60; i++) begin
            bit relax;
            int sz;
            int unsigned span;
            int unsigned base;
            relax = $urandom % 2;
            sz    = relax ? ($urandom % 4) : (2 + $urandom % 3);
            span  = (i % 3 == 0) ? 64 : 1024;
            base  = ($urandom % 4096) * 256;
            if (i % 5 == 0) fill_ordered(base, sz);
            else for (int k = 0; k < LANES; k++)
                la[k] = (base + ($urandom % span)) / (1 << sz) * (1 << sz);
            ready_pct = 30 + (i % 4) * 20;
            run_req(relax, sz, (i % 7 == 0) ? $urandom % 65536 : 16'hffff, "R3 R6 random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule